// File: doc/BRIEF.md
# Three-Phase Deadtime and Interlock Stage

This block sits between a three-phase modulator and the gate-driver output stage. Each phase receives a high-side and a low-side switch command. The command pair for a phase first passes an optional polarity correction. A digital glitch filter then follows, then a cross-conduction interlock, and last a deadtime stage that sets a lower bound on the time both switches are off during a handover. The registered gate enables are then masked by a global kill input and by a per-phase allow mask for the high side. The masking is combinational, so a kill acts in the same cycle and does not wait for any deadtime.

All lengths are counted in clock cycles. `FILT_CYC` sets the filter length and `DEAD_CYC` sets the minimum off time. Every path has the same number of registers, so the command-to-gate latency is the same for both edges and for every channel. The deadtime is only a lower bound. When the modulator already leaves a longer gap, that gap reaches the outputs unchanged.

Top module: `tri_phase_gate_stage`

## Requirements
- R1: A synchronous active-low reset drives every gate output to 0. After reset is released, a command that is already active reaches its output FILT_CYC+1 cycles after the first clock edge that has reset deasserted.
- R2: With ACTIVE_LOW=1, a command input at 0 requests its switch on. With ACTIVE_LOW=0, a 1 requests it on. With complementary input levels, the two variants produce identical outputs cycle for cycle.
- R3: A command level that lasts fewer than FILT_CYC cycles does not change the outputs. This holds for short on-pulses and for short off-dips. A level held for L ≥ FILT_CYC cycles gives an output pulse exactly L cycles wide.
- R4: A command change appears at its gate output exactly FILT_CYC+1 cycles later. This is true for rising and falling edges, for both sides and for all phases, unless R6 holds the change back.
- R5: When both commands of a phase request on, both outputs of that phase are off. The high and low outputs of one phase are never on together.
- R6: Suppose one side's command turns off and the opposite side's command turns on G cycles later. The outputs then show an off gap of exactly max(G, DEAD_CYC) cycles. A turn-off is never delayed.
- R7: The rule of R6 is identical for high-to-low and for low-to-high handovers, and identical in every phase.
- R8: While kill is 1, every gate output is 0 in the same cycle. When kill returns to 0, the outputs again show the state that was held.
- R9: When hi_allow[p] is 0, hi_gate[p] is forced to 0 in the same cycle. The low side of that phase is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_cmd | input | NUM_PHASES | High-side switch command per phase, polarity set by ACTIVE_LOW |
| lo_cmd | input | NUM_PHASES | Low-side switch command per phase, polarity set by ACTIVE_LOW |
| kill | input | 1 | Forces all gate outputs off while 1 |
| hi_allow | input | NUM_PHASES | Per-phase high-side enable mask |
| hi_gate | output | NUM_PHASES | High-side gate enable per phase |
| lo_gate | output | NUM_PHASES | Low-side gate enable per phase |

## Verification
The hardest situation to reach is a handover where the command gap is non-zero but shorter than the deadtime. In that case the second side's turn-on must be delayed by exactly the missing cycles, while its turn-off and the first side's turn-off keep the nominal latency. The bench reaches it with a sweep over every gap from zero to past the deadtime. The sweep runs in both directions and in every phase, and each edge is timed against a cycle counter. Short off-dips inside a long on-command are also driven, to show that the filter holds an already conducting switch steady.

// File: rtl/tpg_pkg.sv
// Package: shared types for the three-phase gate stage.
// Assumes: nothing beyond IEEE 1800-2017.
package tpg_pkg;

    // One phase's pair of side signals (high side, low side).
    typedef struct packed {
        logic hi;
        logic lo;
    } side_pair_t;

endpackage

// File: rtl/tpg_glitch_filter.sv
// Glitch filter: the output takes a new input level only after the input
// has differed from the output on FILT_CYC consecutive clock edges.
// The latency is the same for rising and falling changes.
// Assumes: din is synchronous to clk; FILT_CYC >= 1.
module tpg_glitch_filter #(
    parameter int FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(FILT_CYC - 1);

    logic [CW-1:0] run_cnt;

    // Count edges on which the input disagrees with the output; accept at LIM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= 1'b0;
            run_cnt <= '0;
        end else if (din == dout) begin
            run_cnt <= '0;
        end else if (run_cnt == LIM) begin
            dout    <= din;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R3
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> ($past(din) == dout));

endmodule

// File: rtl/tpg_deadtime.sv
// Deadtime stage: registers the interlocked side requests of one phase.
// A turn-off takes effect at the next edge. A turn-on of the side opposite
// to the one last on waits until both outputs have been off for DEAD_CYC
// cycles. A turn-on of the same side as last on goes through at once.
// Assumes: req_hi and req_lo are never 1 together; DEAD_CYC >= 1.
module tpg_deadtime #(
    parameter int DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_hi,
    input  logic req_lo,
    output logic hi_q,
    output logic lo_q
);
    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] SAT     = DW'(DEAD_CYC);
    localparam logic [DW-1:0] GAP_LIM = DW'(DEAD_CYC - 1);

    logic [DW-1:0] off_cnt;
    logic          last_hi;
    logic          gap_ok;
    logic          hi_nxt;
    logic          lo_nxt;

    // Gap is long enough once both are off and the count reaches GAP_LIM.
    always_comb begin
        gap_ok = !hi_q && !lo_q && (off_cnt >= GAP_LIM);
        hi_nxt = req_hi && !lo_q && (hi_q || last_hi || gap_ok);
        lo_nxt = req_lo && !hi_q && (lo_q || !last_hi || gap_ok);
    end

    // Output registers plus the off-time counter and last-side memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= 1'b0;
            lo_q    <= 1'b0;
            off_cnt <= SAT;
            last_hi <= 1'b0;
        end else begin
            hi_q <= hi_nxt;
            lo_q <= lo_nxt;
            if (hi_q || lo_q)
                off_cnt <= '0;
            else if (off_cnt != SAT)
                off_cnt <= off_cnt + 1'b1;
            if (hi_q)
                last_hi <= 1'b1;
            else if (lo_q)
                last_hi <= 1'b0;
        end
    end

    // Independent checker state: cycles with both sides off, last side on.
    logic [DW-1:0] chk_run;
    logic          chk_prev_hi;

    // Track the observed off gap for the handover assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_run     <= SAT;
            chk_prev_hi <= 1'b0;
        end else begin
            chk_run     <= (hi_q || lo_q) ? '0 :
                           ((chk_run == SAT) ? SAT : chk_run + 1'b1);
            chk_prev_hi <= hi_q ? 1'b1 : (lo_q ? 1'b0 : chk_prev_hi);
        end
    end

    // R5
    never_both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_q && lo_q));

    // R6
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_q && !$past(lo_q) && chk_prev_hi) |-> (chk_run >= SAT));

    // R7
    hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_q && !$past(hi_q) && !chk_prev_hi) |-> (chk_run >= SAT));

    // R6
    prompt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_hi && !req_lo) |=> (!hi_q && !lo_q));

    // R4
    rise_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_q && !$past(hi_q)) |-> $past(req_hi));

endmodule

// File: rtl/tpg_phase_lane.sv
// One phase lane: polarity correction, two glitch filters, interlock and
// deadtime. The output is the unmasked gate pair of this phase.
// Assumes: commands are synchronous to clk.
module tpg_phase_lane
    import tpg_pkg::*;
#(
    parameter int FILT_CYC   = 3,
    parameter int DEAD_CYC   = 4,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_hi,
    input  logic       cmd_lo,
    output side_pair_t gate_raw
);
    side_pair_t corr;
    side_pair_t filt;
    side_pair_t req;

    // Polarity correction picked at build time.
    generate
        if (ACTIVE_LOW) begin : g_inv
            assign corr.hi = ~cmd_hi;
            assign corr.lo = ~cmd_lo;
        end else begin : g_dir
            assign corr.hi = cmd_hi;
            assign corr.lo = cmd_lo;
        end
    endgenerate

    tpg_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt_hi (
        .clk(clk), .rst_n(rst_n), .din(corr.hi), .dout(filt.hi));
    tpg_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt_lo (
        .clk(clk), .rst_n(rst_n), .din(corr.lo), .dout(filt.lo));

    // Interlock: a simultaneous request for both sides yields none.
    always_comb begin
        req.hi = filt.hi && !filt.lo;
        req.lo = filt.lo && !filt.hi;
    end

    tpg_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk(clk), .rst_n(rst_n), .req_hi(req.hi), .req_lo(req.lo),
        .hi_q(gate_raw.hi), .lo_q(gate_raw.lo));

endmodule

// File: rtl/tri_phase_gate_stage.sv
// Top: three (NUM_PHASES) lanes plus the combinational kill/allow masks.
// Masking sits after the deadtime registers so a kill acts in the same cycle.
// Assumes: kill and hi_allow are synchronous to clk.
module tri_phase_gate_stage
    import tpg_pkg::*;
#(
    parameter int NUM_PHASES = 3,
    parameter int FILT_CYC   = 70,
    parameter int DEAD_CYC   = 55,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] hi_cmd,
    input  logic [NUM_PHASES-1:0] lo_cmd,
    input  logic                  kill,
    input  logic [NUM_PHASES-1:0] hi_allow,
    output logic [NUM_PHASES-1:0] hi_gate,
    output logic [NUM_PHASES-1:0] lo_gate
);
    side_pair_t raw [NUM_PHASES];

    generate
        for (genvar p = 0; p < NUM_PHASES; p++) begin : g_ph
            tpg_phase_lane #(
                .FILT_CYC(FILT_CYC), .DEAD_CYC(DEAD_CYC), .ACTIVE_LOW(ACTIVE_LOW)
            ) u_lane (
                .clk(clk), .rst_n(rst_n), .cmd_hi(hi_cmd[p]), .cmd_lo(lo_cmd[p]),
                .gate_raw(raw[p]));

            // Apply the global kill and the high-side allow mask.
            always_comb begin
                hi_gate[p] = raw[p].hi && hi_allow[p] && !kill;
                lo_gate[p] = raw[p].lo && !kill;
            end
        end
    endgenerate

endmodule

// File: tb/tri_phase_gate_stage_tb.sv
`timescale 1ns/100ps
module tri_phase_gate_stage_tb_top;
    localparam int NP = 3;
    localparam int F  = 3;
    localparam int D  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] hi_cmd = '0;
    logic [NP-1:0] lo_cmd = '0;
    logic kill = 1'b0;
    logic [NP-1:0] hi_allow = '1;
    logic [NP-1:0] hi_gate, lo_gate, hi_gate_n, lo_gate_n;

    always #2.5 clk = ~clk;

    tri_phase_gate_stage #(.NUM_PHASES(NP), .FILT_CYC(F), .DEAD_CYC(D), .ACTIVE_LOW(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .kill(kill),
        .hi_allow(hi_allow), .hi_gate(hi_gate), .lo_gate(lo_gate));

    tri_phase_gate_stage #(.NUM_PHASES(NP), .FILT_CYC(F), .DEAD_CYC(D), .ACTIVE_LOW(1'b1)) dut_n_i (
        .clk(clk), .rst_n(rst_n), .hi_cmd(~hi_cmd), .lo_cmd(~lo_cmd), .kill(kill),
        .hi_allow(hi_allow), .hi_gate(hi_gate_n), .lo_gate(lo_gate_n));

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int hi_rise[NP], hi_fall[NP], lo_rise[NP], lo_fall[NP], hi_rn[NP], lo_rn[NP];
    int both_on = 0, pol_mis = 0, samples = 0;
    logic [NP-1:0] hi_prev = '0, lo_prev = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Edge monitor, sampled away from the clock edge.
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
                if (hi_gate[p] && !hi_prev[p]) begin hi_rise[p] = cyc; hi_rn[p]++; end
                if (!hi_gate[p] && hi_prev[p]) hi_fall[p] = cyc;
                if (lo_gate[p] && !lo_prev[p]) begin lo_rise[p] = cyc; lo_rn[p]++; end
                if (!lo_gate[p] && lo_prev[p]) lo_fall[p] = cyc;
                if (hi_gate[p] && lo_gate[p]) both_on++;
            end
            if (hi_gate != hi_gate_n || lo_gate != lo_gate_n) pol_mis++;
            samples++;
        end
        hi_prev = hi_gate;
        lo_prev = lo_gate;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_side(input int p, input int s, input logic v);
        if (s == 0) hi_cmd[p] = v; else lo_cmd[p] = v;
    endtask

    function automatic int rise_of(input int p, input int s);
        return (s == 0) ? hi_rise[p] : lo_rise[p];
    endfunction
    function automatic int fall_of(input int p, input int s);
        return (s == 0) ? hi_fall[p] : lo_fall[p];
    endfunction
    function automatic int rcount(input int p, input int s);
        return (s == 0) ? hi_rn[p] : lo_rn[p];
    endfunction

    // R6 R7: handover from side s to the other side with command gap g.
    task automatic handover(input int p, input int s, input int g);
        int c0, c1, c2, e;
        set_side(p, s, 1'b1); c0 = cyc; idle(12);
        chk(rise_of(p, s) == c0 + F + 1, "R4 turn-on latency", rise_of(p, s), c0 + F + 1);
        set_side(p, s, 1'b0); c1 = cyc;
        if (g > 0) idle(g);
        set_side(p, 1 - s, 1'b1); idle(20);
        chk(fall_of(p, s) == c1 + F + 1, "R4 turn-off latency", fall_of(p, s), c1 + F + 1);
        e = c1 + F + 1 + ((g > D) ? g : D);
        chk(rise_of(p, 1 - s) == e, (s == 0) ? "R6 hi-to-lo gap" : "R7 lo-to-hi gap",
            rise_of(p, 1 - s), e);
        set_side(p, 1 - s, 1'b0); c2 = cyc; idle(12);
        chk(fall_of(p, 1 - s) == c2 + F + 1, "R4 second-side turn-off", fall_of(p, 1 - s), c2 + F + 1);
    endtask

    // R3: an on-pulse of L cycles on side s of phase p.
    task automatic pulse(input int p, input int s, input int l);
        int c, n0;
        n0 = rcount(p, s);
        set_side(p, s, 1'b1); c = cyc; idle(l);
        set_side(p, s, 1'b0); idle(15);
        if (l < F) begin
            chk(rcount(p, s) == n0, "R3 short pulse rejected", rcount(p, s), n0);
        end else begin
            chk(rise_of(p, s) == c + F + 1, "R3 pulse start", rise_of(p, s), c + F + 1);
            chk(fall_of(p, s) == c + l + F + 1, "R3 pulse width", fall_of(p, s), c + l + F + 1);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int c, f0, n0, m0;
        // R1: reset with a command already present.
        hi_cmd[0] = 1'b1;
        idle(5);
        chk(hi_gate == '0 && lo_gate == '0, "R1 outputs off in reset", {hi_gate, lo_gate}, 0);
        rst_n = 1'b1; c = cyc;
        idle(1);
        chk(hi_gate == '0 && lo_gate == '0, "R1 outputs off after reset", {hi_gate, lo_gate}, 0);
        idle(10);
        chk(hi_rise[0] == c + F + 1, "R1 first turn-on after reset", hi_rise[0], c + F + 1);
        hi_cmd[0] = 1'b0; idle(15);

        // R6 R7: handover sweep over all phases, both directions, gaps 0..D+3.
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < 2; s++)
                for (int g = 0; g <= D + 3; g++)
                    handover(p, s, g);

        // R3: pulse widths around the filter length.
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < 2; s++)
                for (int l = 1; l <= F + 2; l++)
                    pulse(p, s, l);

        // R3: short off-dip inside a long on-command.
        for (int p = 0; p < NP; p++) begin
            hi_cmd[p] = 1'b1; idle(15);
            f0 = hi_fall[p];
            hi_cmd[p] = 1'b0; idle(F - 1);
            hi_cmd[p] = 1'b1; idle(15);
            chk(hi_fall[p] == f0 && hi_gate[p], "R3 short dip ignored", hi_fall[p], f0);
            hi_cmd[p] = 1'b0; idle(15);
        end

        // R5: simultaneous request, then an overlap.
        n0 = hi_rn[1]; m0 = lo_rn[1];
        hi_cmd[1] = 1'b1; lo_cmd[1] = 1'b1; idle(20);
        chk(hi_rn[1] == n0 && lo_rn[1] == m0, "R5 both requested gives none",
            hi_rn[1] + lo_rn[1], n0 + m0);
        hi_cmd[1] = 1'b0; lo_cmd[1] = 1'b0; idle(15);
        hi_cmd[1] = 1'b1; idle(15);
        lo_cmd[1] = 1'b1; c = cyc; idle(15);
        chk(hi_fall[1] == c + F + 1, "R5 overlap turns high side off", hi_fall[1], c + F + 1);
        chk(lo_rn[1] == m0, "R5 low side held off during overlap", lo_rn[1], m0);
        hi_cmd[1] = 1'b0; c = cyc; idle(20);
        chk(lo_rise[1] == c + F + 1, "R5 low side after overlap ends", lo_rise[1], c + F + 1);
        lo_cmd[1] = 1'b0; idle(15);

        // R8 R9: kill and allow masks.
        hi_cmd[0] = 1'b1; lo_cmd[1] = 1'b1; idle(15);
        kill = 1'b1; #1;
        chk(hi_gate == '0 && lo_gate == '0, "R8 kill forces off", {hi_gate, lo_gate}, 0);
        idle(3);
        kill = 1'b0; #1;
        chk(hi_gate[0] && lo_gate[1], "R8 release restores", {hi_gate[0], lo_gate[1]}, 3);
        idle(1);
        hi_allow[0] = 1'b0; #1;
        chk(!hi_gate[0] && lo_gate[1], "R9 allow mask high side only", {hi_gate[0], lo_gate[1]}, 1);
        idle(1);
        hi_allow[0] = 1'b1; #1;
        chk(hi_gate[0], "R9 allow restored", hi_gate[0], 1);
        hi_cmd[0] = 1'b0; lo_cmd[1] = 1'b0; idle(15);

        // R5: never both on; R2: polarity variants identical.
        chk(both_on == 0, "R5 both sides never on together", both_on, 0);
        chk(pol_mis == 0 && samples > 0, "R2 active-low variant matches", pol_mis, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule